// File: doc/BRIEF.md
# I2C Master Clock and Data Timing Generator

This block sets the timing of each bit an I2C master sends. For every bit it drives the SCL line low for a programmed number of system clock cycles and then releases it for a second programmed number of cycles. Inside the low phase it picks the one cycle in which SDA may change. Both lines are open-drain, so the outputs are drive-low requests: a 1 pulls the wire low and a 0 releases it. All durations are counted in system clock cycles.

A byte engine sits next to the block. It raises a bit request together with the bit value. The block takes the request, runs one SCL low phase and one SCL high phase for that bit, and marks three events with single-cycle strobes: the SCL falling edge, the SDA update point and the SCL rising edge. If the request is still high at the end of a high phase, the next bit follows at once. If it is low, SCL stays released and the block waits.

The block latches three 8-bit settings when it takes a bit: a low-period value, a high-period value and an SDA hold value. A setting that would put the SDA change at or after the SCL rise is clamped, and a sticky flag records it.

Top module: `i2c_master_timing`

## Requirements
- R1: After reset both drive-low outputs are 0, all three strobes are 0 and the configuration-error flag is 0.
- R2: The SCL low phase lasts 4*LOW+14 cycles. The falling strobe is high in the first low cycle and the rising strobe is high in the first cycle after the low phase.
- R3: The SCL high phase lasts 4*HIGH+2 cycles. With the request held, the next falling strobe comes 4*HIGH+2 cycles after the rising strobe, so one full bit takes 4*(LOW+HIGH+4) cycles.
- R4: The SDA update strobe pulses HOLD+2 cycles after the falling strobe. In that same cycle the SDA drive-low output becomes the inverse of the bit value (bit 0 drives the line low, bit 1 releases it). At no other time does it change while enable stays high.
- R5: When HOLD+2 is at least 4*LOW+14, the update strobe comes in the last low cycle, one cycle before the rising strobe. The error flag is then set, and it stays set until enable is taken low.
- R6: LOW, HIGH and HOLD are latched when a bit is taken. A setting changed after that applies only to the next bit.
- R7: In the cycle after enable is seen low, both drive-low outputs are 0, the error flag is 0 and the counters are at zero. The next bit after enable returns starts a fresh period.
- R8: Each strobe is high for exactly one cycle, and no two strobes are ever high in the same cycle.
- R9: A request is taken only while the block is idle or in the last cycle of a high phase. The falling strobe follows in the next cycle. With no request at the end of a high phase, SCL stays released and no falling strobe comes.
- R10: The bit value is latched when the request is taken. A change of the bit input after that does not affect the SDA drive for that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low releases both lines and clears state |
| bit_req_i | input | 1 | Request to send one bit |
| bit_i | input | 1 | Bit value for the request |
| low_cfg_i | input | 8 | SCL low-period setting LOW |
| high_cfg_i | input | 8 | SCL high-period setting HIGH |
| hold_cfg_i | input | 8 | SDA hold setting HOLD |
| scl_drive_low_o | output | 1 | 1 pulls SCL low |
| sda_drive_low_o | output | 1 | 1 pulls SDA low |
| scl_fall_o | output | 1 | Strobe in the first SCL low cycle |
| scl_rise_o | output | 1 | Strobe in the first SCL released cycle |
| sda_upd_o | output | 1 | Strobe in the cycle SDA takes its new value |
| cfg_err_o | output | 1 | Sticky flag: SDA update was clamped |

## Verification
Two things can fall in the same cycle. A settings write can coincide with the start of a bit, and a change of the bit input can coincide with the latching of the old bit. The bench writes new settings and a new bit value in the very cycle the falling strobe appears, and keeps the request high across the period boundary. It then expects the first bit to show the old timing and the old value throughout, and the second bit to show the new ones. A second case is the clamped update landing right next to the rising edge. Hold values are swept across the clamp threshold for several low settings, and the bench checks that the update and rise strobes never overlap.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;

   localparam int LOW_OFFSET_LAST  = 13;
   localparam int HIGH_OFFSET_LAST = 1;
   localparam int HOLD_OFFSET_LAST = 1;

endpackage

// File: rtl/i2c_tg_tc_calc.sv
module i2c_tg_tc_calc #(
   parameter int CFG_W = 8,
   parameter int CNT_W = CFG_W + 3
) (
   input  logic [CFG_W-1:0] low_cfg_i,
   input  logic [CFG_W-1:0] high_cfg_i,
   input  logic [CFG_W-1:0] hold_cfg_i,
   output logic [CNT_W-1:0] low_last_o,
   output logic [CNT_W-1:0] high_last_o,
   output logic [CNT_W-1:0] upd_last_o,
   output logic             clamp_o
);
   import i2c_tg_pkg::*;

   localparam int PAD4 = CNT_W - CFG_W - 2;
   localparam int PAD1 = CNT_W - CFG_W;

   if (CFG_W < 2) begin : g_bad_cfg_w
      $error("i2c_tg_tc_calc: CFG_W must be at least 2");
   end
   if (CNT_W < CFG_W + 3) begin : g_bad_cnt_w
      $error("i2c_tg_tc_calc: CNT_W too small for 4*max+14");
   end

   logic [CNT_W-1:0] hold_last;

   always_comb begin
      low_last_o  = {{PAD4{1'b0}}, low_cfg_i, 2'b00} + CNT_W'(LOW_OFFSET_LAST);
      high_last_o = {{PAD4{1'b0}}, high_cfg_i, 2'b00} + CNT_W'(HIGH_OFFSET_LAST);
      hold_last   = {{PAD1{1'b0}}, hold_cfg_i} + CNT_W'(HOLD_OFFSET_LAST);
      clamp_o     = (hold_last >= low_last_o);
      upd_last_o  = clamp_o ? (low_last_o - CNT_W'(1)) : hold_last;
   end

endmodule

// File: rtl/i2c_tg_scl_fsm.sv
module i2c_tg_scl_fsm #(
   parameter int CNT_W = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             req_i,
   input  logic [CNT_W-1:0] low_last_i,
   input  logic [CNT_W-1:0] high_last_i,
   input  logic [CNT_W-1:0] upd_last_i,
   input  logic             clamp_i,
   output logic             accept_o,
   output logic             upd_now_o,
   output logic             scl_low_o,
   output logic             fall_o,
   output logic             rise_o,
   output logic             err_o
);
   import i2c_tg_pkg::*;

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] low_last_q;
   logic [CNT_W-1:0] high_last_q;
   logic [CNT_W-1:0] upd_last_q;
   logic             high_end;

   assign high_end  = (phase_q == PH_HIGH) && (cnt_q == high_last_q);
   assign accept_o  = en_i && req_i && ((phase_q == PH_IDLE) || high_end);
   assign upd_now_o = (phase_q == PH_LOW) && (cnt_q == upd_last_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q     <= PH_IDLE;
         cnt_q       <= '0;
         low_last_q  <= '0;
         high_last_q <= '0;
         upd_last_q  <= '0;
         scl_low_o   <= 1'b0;
         fall_o      <= 1'b0;
         rise_o      <= 1'b0;
         err_o       <= 1'b0;
      end else if (!en_i) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         scl_low_o <= 1'b0;
         fall_o    <= 1'b0;
         rise_o    <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         fall_o <= 1'b0;
         rise_o <= 1'b0;
         if (accept_o) begin
            phase_q     <= PH_LOW;
            cnt_q       <= '0;
            low_last_q  <= low_last_i;
            high_last_q <= high_last_i;
            upd_last_q  <= upd_last_i;
            scl_low_o   <= 1'b1;
            fall_o      <= 1'b1;
            err_o       <= err_o | clamp_i;
         end else begin
            unique case (phase_q)
               PH_LOW: begin
                  if (cnt_q == low_last_q) begin
                     phase_q   <= PH_HIGH;
                     cnt_q     <= '0;
                     scl_low_o <= 1'b0;
                     rise_o    <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               PH_HIGH: begin
                  if (high_end) begin
                     phase_q <= PH_IDLE;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               default: begin
                  cnt_q <= '0;
               end
            endcase
         end
      end
   end

   a_r2_fall_is_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |-> (scl_low_o && !$past(scl_low_o)));

   a_r3_rise_is_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |-> (!scl_low_o && $past(scl_low_o)));

   a_r7_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!scl_low_o && phase_q == PH_IDLE && cnt_q == '0 && !err_o));

   a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && err_o) |=> err_o);

   a_r5_upd_inside_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_LOW) |-> (upd_last_q < low_last_q));

endmodule

// File: rtl/i2c_tg_sda_ctl.sv
module i2c_tg_sda_ctl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic accept_i,
   input  logic bit_i,
   input  logic upd_now_i,
   output logic sda_low_o,
   output logic upd_o
);

   logic bit_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bit_q     <= 1'b1;
         sda_low_o <= 1'b0;
         upd_o     <= 1'b0;
      end else if (!en_i) begin
         bit_q     <= 1'b1;
         sda_low_o <= 1'b0;
         upd_o     <= 1'b0;
      end else begin
         upd_o <= upd_now_i;
         if (accept_i) begin
            bit_q <= bit_i;
         end
         if (upd_now_i) begin
            sda_low_o <= ~bit_q;
         end
      end
   end

   a_r4_sda_moves_on_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(en_i) && en_i && !upd_o) |-> $stable(sda_low_o));

   a_r8_upd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o |=> !upd_o);

endmodule

// File: rtl/i2c_master_timing.sv
module i2c_master_timing #(
   parameter int CFG_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             bit_req_i,
   input  logic             bit_i,
   input  logic [CFG_W-1:0] low_cfg_i,
   input  logic [CFG_W-1:0] high_cfg_i,
   input  logic [CFG_W-1:0] hold_cfg_i,
   output logic             scl_drive_low_o,
   output logic             sda_drive_low_o,
   output logic             scl_fall_o,
   output logic             scl_rise_o,
   output logic             sda_upd_o,
   output logic             cfg_err_o
);

   localparam int CNT_W = CFG_W + 3;

   logic [CNT_W-1:0] low_last;
   logic [CNT_W-1:0] high_last;
   logic [CNT_W-1:0] upd_last;
   logic             clamp;
   logic             accept;
   logic             upd_now;

   i2c_tg_tc_calc #(
      .CFG_W (CFG_W),
      .CNT_W (CNT_W)
   ) u_tc_calc (
      .low_cfg_i   (low_cfg_i),
      .high_cfg_i  (high_cfg_i),
      .hold_cfg_i  (hold_cfg_i),
      .low_last_o  (low_last),
      .high_last_o (high_last),
      .upd_last_o  (upd_last),
      .clamp_o     (clamp)
   );

   i2c_tg_scl_fsm #(
      .CNT_W (CNT_W)
   ) u_scl_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_i),
      .req_i       (bit_req_i),
      .low_last_i  (low_last),
      .high_last_i (high_last),
      .upd_last_i  (upd_last),
      .clamp_i     (clamp),
      .accept_o    (accept),
      .upd_now_o   (upd_now),
      .scl_low_o   (scl_drive_low_o),
      .fall_o      (scl_fall_o),
      .rise_o      (scl_rise_o),
      .err_o       (cfg_err_o)
   );

   i2c_tg_sda_ctl u_sda_ctl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .accept_i  (accept),
      .bit_i     (bit_i),
      .upd_now_i (upd_now),
      .sda_low_o (sda_drive_low_o),
      .upd_o     (sda_upd_o)
   );

   a_r8_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({scl_fall_o, scl_rise_o, sda_upd_o}));

   a_r5_update_before_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sda_upd_o |-> scl_drive_low_o);

endmodule

// File: tb/i2c_master_timing_bench.sv
module i2c_master_timing_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       req = 1'b0;
   logic       bit_v = 1'b1;
   logic [7:0] low_cfg = '0;
   logic [7:0] high_cfg = '0;
   logic [7:0] hold_cfg = '0;
   logic       scl_low, sda_low, fall, rise, upd, err;

   int n_chk = 0;
   int n_bad = 0;
   int clash = 0;
   int longs = 0;
   logic prev_f = 0, prev_r = 0, prev_u = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_master_timing u_i2c_master_timing (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .en_i            (en),
      .bit_req_i       (req),
      .bit_i           (bit_v),
      .low_cfg_i       (low_cfg),
      .high_cfg_i      (high_cfg),
      .hold_cfg_i      (hold_cfg),
      .scl_drive_low_o (scl_low),
      .sda_drive_low_o (sda_low),
      .scl_fall_o      (fall),
      .scl_rise_o      (rise),
      .sda_upd_o       (upd),
      .cfg_err_o       (err)
   );

   // R8 monitor: no overlap, no strobe longer than one cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if ((int'(fall) + int'(rise) + int'(upd)) > 1) clash++;
         if ((fall && prev_f) || (rise && prev_r) || (upd && prev_u)) longs++;
      end
      prev_f = fall; prev_r = rise; prev_u = upd;
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int exp_low(input int lo);
      return 4 * lo + 14;
   endfunction
   function automatic int exp_high(input int hi);
      return 4 * hi + 2;
   endfunction
   function automatic int exp_upd(input int lo, input int ho);
      return (ho + 2 >= exp_low(lo)) ? exp_low(lo) - 1 : ho + 2;
   endfunction
   function automatic bit exp_clamp(input int lo, input int ho);
      return (ho + 2 >= exp_low(lo));
   endfunction

   task automatic run_pair(input int lo1, input int hi1, input int ho1, input bit b1,
                           input int lo2, input int hi2, input int ho2, input bit b2);
      int k, tu, tr, tf, tu2, tr2, nf;
      bit sda_at1, sda_at2;
      @(negedge clk);
      low_cfg = 8'(lo1); high_cfg = 8'(hi1); hold_cfg = 8'(ho1);
      bit_v = b1; req = 1'b1;
      k = 0;
      do begin @(negedge clk); k++; end while (!fall && k < 5);
      chk(k == 1, "R9 idle accept to fall", k, 1);
      // same cycle as fall: new settings and new bit (R6, R10)
      low_cfg = 8'(lo2); high_cfg = 8'(hi2); hold_cfg = 8'(ho2); bit_v = b2;
      k = 0; tu = -1; tr = -1; tf = -1; sda_at1 = 0;
      while (tf < 0 && k < 3000) begin
         @(negedge clk); k++;
         if (upd) begin tu = k; sda_at1 = sda_low; end
         if (rise) tr = k;
         if (fall) tf = k;
      end
      chk(tr == exp_low(lo1), "R2 low length", tr, exp_low(lo1));
      chk(tu == exp_upd(lo1, ho1), "R4/R5 update point", tu, exp_upd(lo1, ho1));
      chk(sda_at1 == !b1, "R10 sda from latched bit", sda_at1, !b1);
      chk(tf - tr == exp_high(hi1), "R3 high length", tf - tr, exp_high(hi1));
      req = 1'b0;
      k = 0; tu2 = -1; tr2 = -1; sda_at2 = 0;
      while (tr2 < 0 && k < 3000) begin
         @(negedge clk); k++;
         if (upd) begin tu2 = k; sda_at2 = sda_low; end
         if (rise) tr2 = k;
      end
      chk(tr2 == exp_low(lo2), "R6 next-bit low length", tr2, exp_low(lo2));
      chk(tu2 == exp_upd(lo2, ho2), "R6 next-bit update", tu2, exp_upd(lo2, ho2));
      chk(sda_at2 == !b2, "R4 sda value", sda_at2, !b2);
      nf = 0;
      for (int i = 0; i < exp_high(hi2) + 3; i++) begin
         @(negedge clk);
         if (fall) nf++;
      end
      chk(nf == 0 && !scl_low, "R9 no request stays idle", nf, 0);
      chk(err == (exp_clamp(lo1, ho1) | exp_clamp(lo2, ho2)), "R5 sticky error",
          err, exp_clamp(lo1, ho1) | exp_clamp(lo2, ho2));
      en = 1'b0;
      @(negedge clk);
      chk(!scl_low && !sda_low && !err, "R7 disable releases",
          {scl_low, sda_low, err}, 0);
      en = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int holds[6];
      int k;
      holds = '{0, 11, 12, 15, 16, 255};
      repeat (3) @(negedge clk);
      chk(!scl_low && !sda_low && !fall && !rise && !upd && !err, "R1 reset state",
          {scl_low, sda_low, fall, rise, upd, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      chk(!scl_low && !sda_low && !err, "R1 idle after reset",
          {scl_low, sda_low, err}, 0);

      for (int lo = 0; lo < 4; lo++)
         for (int hi = 0; hi < 3; hi++)
            for (int h = 0; h < 6; h++)
               run_pair(lo, hi, holds[h], 1'((lo + h) & 1),
                        3 - lo, (hi + 1) % 3, holds[(h + 2) % 6], 1'((lo + h + 1) & 1));

      // R7: enable dropped inside a low phase, then a fresh period
      @(negedge clk);
      low_cfg = 8'd2; high_cfg = 8'd1; hold_cfg = 8'd3; bit_v = 1'b0; req = 1'b1;
      @(negedge clk);
      chk(fall == 1'b1, "R9 fall after idle accept", fall, 1);
      req = 1'b0;
      repeat (10) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(!scl_low && !sda_low && !fall && !rise && !upd, "R7 mid-period disable",
          {scl_low, sda_low, fall, rise, upd}, 0);
      @(negedge clk);
      en = 1'b1; req = 1'b1; low_cfg = 8'd0;
      @(negedge clk);
      chk(fall == 1'b1, "R7 restart fall", fall, 1);
      req = 1'b0;
      k = 0;
      do begin @(negedge clk); k++; end while (!rise && k < 100);
      chk(k == 14, "R7 fresh low length", k, 14);
      repeat (10) @(negedge clk);

      chk(clash == 0, "R8 strobe overlap", clash, 0);
      chk(longs == 0, "R8 strobe width", longs, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule